// File: doc/BRIEF.md
# Row-Buffer-Aware DRAM Request Scheduler

This block is the request scheduler of a memory controller for one channel that carries a single rank of eight banks. It takes read requests from two sources, the memory stage and the fetch stage, holds them in an ordered queue and, in every cycle, issues at most one request. A request can be issued only if its entire future command sequence fits into the timing already committed to earlier requests. That sequence is one, two or three commands, depending on the state of the target bank's row buffer. The fit is checked against the command/address bus, the target bank and the data bus.

The scheduler records which row each bank holds open. It keeps the commitments as down-counters, so the decision is made in one cycle from the current state together with the requests arriving in that cycle. When a request's data transfer reaches its final cycle, the block reports the request's address and source on the completion outputs. The requesters use this as the fill notice.

Top module: `dram_row_sched`

## Requirements
- R1: After reset, no completion is reported, `q_full` is low and every bank's row buffer is closed.
- R2: A request's bank is address bits [7:5] and its row is address bits [31:16]. Bits [15:8] and [4:0] do not affect scheduling.
- R3: The number of commands depends on the row buffer. A request to a closed bank needs 2 commands, a request to the open row needs 1, and a request to another row needs 3. The issued row becomes the bank's open row. A request issued in cycle T therefore completes in cycle T+249, T+149 or T+349 respectively.
- R4: Command k of a request issued in cycle T occupies the command bus for cycles T+100k to T+100k+3. Its data occupies the data bus for 50 cycles starting 100 cycles after its last command. A request is issued only if none of these cycles is already taken.
- R5: Each command keeps its bank busy for 100 cycles. A bank accepts a new request only once every cycle committed to its previous one has passed.
- R6: At most one request is issued per cycle. A request that arrives in a cycle can be issued in that same cycle.
- R7: Among the requests that can issue, a request to an open row wins over every other request, including older ones.
- R8: Among equally qualified candidates, the earliest arrival wins. A memory-stage and a fetch-stage request that arrive in the same cycle are ordered memory-stage first.
- R9: `done_valid` is high for exactly the last cycle of a request's data transfer. In that cycle `done_addr` carries the request's address and `done_mem` is 1 for a memory-stage request and 0 for a fetch-stage request. At most one completion occurs per cycle.
- R10: `q_full` is high while the queue holds 15 or more of its 16 entries. Requests presented on either port while `q_full` is high are discarded and never complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq_valid | input | 1 | Memory-stage request present this cycle |
| mreq_addr | input | 32 | Memory-stage request address |
| freq_valid | input | 1 | Fetch-stage request present this cycle |
| freq_addr | input | 32 | Fetch-stage request address |
| q_full | output | 1 | Queue has fewer than two free entries; new requests are dropped |
| done_valid | output | 1 | Final data cycle of a completed request |
| done_addr | output | 32 | Address of the completing request |
| done_mem | output | 1 | Completing request came from the memory stage |

## Verification
Two functions can meet in the same cycle. In one case, a freshly arriving request competes with requests already waiting in the queue. In the other, requests from both ports are enqueued while a third, older request issues. The bench provokes these in two ways. It presents memory-stage and fetch-stage requests together, and it releases a blocked older miss and a newer row hit onto the command bus in the same cycle. It judges the outcome by the exact completion cycle of each request and by comparison against a behavioural model that books absolute cycle numbers. It also drives both ports into a nearly full queue and confirms that the requests dropped there never complete.

// File: rtl/dram_row_sched.sv
module dram_row_sched #(
  parameter int AW      = 32,
  parameter int NB      = 8,
  parameter int BANK_LO = 5,
  parameter int ROW_LO  = 16,
  parameter int DEPTH   = 16,
  parameter int T_CMD   = 4,
  parameter int T_BANK  = 100,
  parameter int T_DATA  = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mreq_valid,
  input  logic [AW-1:0] mreq_addr,
  input  logic          freq_valid,
  input  logic [AW-1:0] freq_addr,
  output logic          q_full,
  output logic          done_valid,
  output logic [AW-1:0] done_addr,
  output logic          done_mem
);
  localparam int BW = $clog2(NB);
  localparam int RW = AW - ROW_LO;
  localparam int QW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(3*T_BANK + T_DATA + 1);

  logic [AW-1:0]    q_addr [DEPTH];
  logic [DEPTH-1:0] q_mem;
  logic [QW-1:0]    qcnt;

  logic [CW-1:0] bcnt [NB];
  logic [CW-1:0] da_cnt [NB];
  logic [CW-1:0] db_cnt [NB];
  logic [AW-1:0] da_addr [NB];
  logic [AW-1:0] db_addr [NB];
  logic [NB-1:0] da_mem, db_mem, ropen;
  logic [RW-1:0] rrow [NB];

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic dclash(input logic [CW-1:0] d, input int m);
    return (int'(d) >= m*T_BANK + 1) && (int'(d) <= m*T_BANK + 2*T_DATA - 1);
  endfunction

  assign q_full = (qcnt >= QW'(DEPTH - 1));

  logic acc_m, acc_f;
  assign acc_m = mreq_valid && !q_full;
  assign acc_f = freq_valid && !q_full;

  logic [2:0] cmd_ok, fit;
  always_comb begin
    for (int o = 0; o < 3; o++) begin
      cmd_ok[o] = 1'b1;
      for (int j = 0; j < NB; j++)
        for (int k = 1; k <= 3; k++)
          if ((int'(bcnt[j]) - k*T_BANK - o*T_BANK <= T_CMD - 1) &&
              (o*T_BANK + k*T_BANK - int'(bcnt[j]) <= T_CMD - 1))
            cmd_ok[o] = 1'b0;
    end
    for (int m = 1; m <= 3; m++) begin
      fit[m-1] = 1'b1;
      for (int o = 0; o < m; o++) fit[m-1] = fit[m-1] & cmd_ok[o];
      for (int j = 0; j < NB; j++)
        if (dclash(da_cnt[j], m) || dclash(db_cnt[j], m)) fit[m-1] = 1'b0;
    end
  end

  logic [AW-1:0]    c_addr [DEPTH];
  logic [1:0]       c_n [DEPTH];
  logic [DEPTH-1:0] c_mem, c_v, c_hit, c_ok;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      c_addr[i] = q_addr[i];
      c_mem[i]  = q_mem[i];
      c_v[i]    = (i < int'(qcnt));
      if (!c_v[i]) begin
        if (acc_m && i == int'(qcnt)) begin
          c_addr[i] = mreq_addr; c_mem[i] = 1'b1; c_v[i] = 1'b1;
        end else if (acc_f && i == int'(qcnt) + int'(acc_m)) begin
          c_addr[i] = freq_addr; c_mem[i] = 1'b0; c_v[i] = 1'b1;
        end
      end
      c_hit[i] = ropen[c_addr[i][BANK_LO +: BW]] &&
                 (rrow[c_addr[i][BANK_LO +: BW]] == c_addr[i][AW-1:ROW_LO]);
      c_n[i]   = c_hit[i] ? 2'd1 : (ropen[c_addr[i][BANK_LO +: BW]] ? 2'd3 : 2'd2);
      c_ok[i]  = c_v[i] && (bcnt[c_addr[i][BANK_LO +: BW]] == '0) && fit[c_n[i] - 2'd1];
    end
  end

  logic          iss, hit_f;
  logic [IW-1:0] osel, hsel, sel;
  always_comb begin
    hit_f = 1'b0;
    osel  = '0;
    hsel  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (c_ok[i]) osel = IW'(i);
      if (c_ok[i] && c_hit[i]) begin hsel = IW'(i); hit_f = 1'b1; end
    end
  end
  assign iss = |c_ok;
  assign sel = hit_f ? hsel : osel;

  logic [AW-1:0] iss_addr;
  logic [1:0]    iss_n;
  logic          iss_mem;
  logic [BW-1:0] iss_bank;
  assign iss_addr = c_addr[sel];
  assign iss_n    = c_n[sel];
  assign iss_mem  = c_mem[sel];
  assign iss_bank = iss_addr[BANK_LO +: BW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qcnt  <= '0;
      q_mem <= '0;
      ropen <= '0;
      da_mem <= '0;
      db_mem <= '0;
      for (int i = 0; i < DEPTH; i++) q_addr[i] <= '0;
      for (int j = 0; j < NB; j++) begin
        bcnt[j] <= '0; da_cnt[j] <= '0; db_cnt[j] <= '0;
        da_addr[j] <= '0; db_addr[j] <= '0; rrow[j] <= '0;
      end
    end else begin
      qcnt <= qcnt + QW'(acc_m) + QW'(acc_f) - QW'(iss);
      for (int i = 0; i < DEPTH; i++) begin
        if (iss && i >= int'(sel)) begin
          q_addr[i] <= c_addr[(i + 1) % DEPTH];
          q_mem[i]  <= c_mem[(i + 1) % DEPTH];
        end else begin
          q_addr[i] <= c_addr[i];
          q_mem[i]  <= c_mem[i];
        end
      end
      for (int j = 0; j < NB; j++) begin
        if (iss && int'(iss_bank) == j) begin
          bcnt[j]    <= CW'(int'(iss_n) * T_BANK - 1);
          da_cnt[j]  <= CW'(int'(iss_n) * T_BANK + T_DATA - 1);
          da_addr[j] <= iss_addr;
          da_mem[j]  <= iss_mem;
          db_cnt[j]  <= dec(da_cnt[j]);
          db_addr[j] <= da_addr[j];
          db_mem[j]  <= da_mem[j];
          ropen[j]   <= 1'b1;
          rrow[j]    <= iss_addr[AW-1:ROW_LO];
        end else begin
          bcnt[j]   <= dec(bcnt[j]);
          da_cnt[j] <= dec(da_cnt[j]);
          db_cnt[j] <= dec(db_cnt[j]);
        end
      end
    end
  end

  logic [2*NB-1:0] dvec;
  always_comb begin
    done_addr = '0;
    done_mem  = 1'b0;
    for (int j = 0; j < NB; j++) begin
      dvec[j]      = (da_cnt[j] == CW'(1));
      dvec[NB + j] = (db_cnt[j] == CW'(1));
      if (dvec[j])      begin done_addr = da_addr[j]; done_mem = da_mem[j]; end
      if (dvec[NB + j]) begin done_addr = db_addr[j]; done_mem = db_mem[j]; end
    end
  end
  assign done_valid = |dvec;

  // R9
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dvec));

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |=> qcnt <= $past(qcnt));

  // R10
  qcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) qcnt <= QW'(DEPTH));

  // R3
  row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss |=> ropen[$past(iss_bank)] && (rrow[$past(iss_bank)] == $past(iss_addr[AW-1:ROW_LO])));

  for (genvar g = 0; g < NB; g++) begin : g_bank_chk
    // R5
    bank_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt[g] != '0 |=> bcnt[g] == $past(bcnt[g]) - 1'b1);
  end
endmodule

// File: tb/dram_row_sched_tb_top.sv
module dram_row_sched_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mreq_valid = 1'b0, freq_valid = 1'b0;
  logic [31:0] mreq_addr = '0, freq_addr = '0;
  logic q_full, done_valid, done_mem;
  logic [31:0] done_addr;

  always #2.5 clk = ~clk;

  dram_row_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
    .freq_valid(freq_valid), .freq_addr(freq_addr),
    .q_full(q_full), .done_valid(done_valid),
    .done_addr(done_addr), .done_mem(done_mem)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: absolute-cycle bookings
  typedef struct { logic [31:0] a; bit m; } mreq_t;
  mreq_t mq[$];
  int cmd_s[$], dat_s[$];
  int bfree[8];
  bit mop[8];
  int mrow[8];
  int ev_t[$];
  logic [31:0] ev_a[$];
  bit ev_m[$];
  int got_t[$];
  logic [31:0] got_a[$];
  bit got_m[$];

  function automatic int ncmd_of(logic [31:0] a);
    int b = int'(a[7:5]);
    if (mop[b] && mrow[b] == int'(a[31:16])) return 1;
    if (mop[b]) return 3;
    return 2;
  endfunction

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic bit can_go(logic [31:0] a, int t);
    int b = int'(a[7:5]);
    int n = ncmd_of(a);
    if (t < bfree[b]) return 0;
    for (int i = 0; i < n; i++)
      foreach (cmd_s[k]) if (iabs(cmd_s[k] - (t + 100*i)) <= 3) return 0;
    foreach (dat_s[k]) if (iabs(dat_s[k] - (t + 100*n)) < 50) return 0;
    return 1;
  endfunction

  task automatic model_step(int t);
    int pick = -1;
    int keep[$];
    if (mq.size() < 15) begin
      if (mreq_valid) mq.push_back('{mreq_addr, 1'b1});
      if (freq_valid) mq.push_back('{freq_addr, 1'b0});
    end
    foreach (mq[i]) if (pick < 0 && ncmd_of(mq[i].a) == 1 && can_go(mq[i].a, t)) pick = i;
    if (pick < 0) foreach (mq[i]) if (pick < 0 && can_go(mq[i].a, t)) pick = i;
    if (pick >= 0) begin
      logic [31:0] a = mq[pick].a;
      int n = ncmd_of(a);
      int b = int'(a[7:5]);
      for (int i = 0; i < n; i++) cmd_s.push_back(t + 100*i);
      dat_s.push_back(t + 100*n);
      bfree[b] = t + 100*n;
      mop[b] = 1'b1;
      mrow[b] = int'(a[31:16]);
      ev_t.push_back(t + 100*n + 49);
      ev_a.push_back(a);
      ev_m.push_back(mq[pick].m);
      mq.delete(pick);
    end
    keep = {};
    foreach (cmd_s[k]) if (cmd_s[k] >= t - 10) keep.push_back(cmd_s[k]);
    cmd_s = keep;
    keep = {};
    foreach (dat_s[k]) if (dat_s[k] >= t - 100) keep.push_back(dat_s[k]);
    dat_s = keep;
  endtask

  always @(posedge clk) begin
    if (rst_n) model_step(cyc);
    cyc = cyc + 1;
  end

  always @(negedge clk) begin
    int hit;
    if (rst_n) begin
      hit = -1;
      foreach (ev_t[i]) if (ev_t[i] == cyc) hit = i;
      chk("R9 done_valid", 64'(done_valid), 64'(hit >= 0));
      if (hit >= 0 && done_valid) begin
        chk("R9 done_addr", 64'(done_addr), 64'(ev_a[hit]));
        chk("R9 done_mem", 64'(done_mem), 64'(ev_m[hit]));
      end
      chk("R10 q_full", 64'(q_full), 64'(mq.size() >= 15));
      if (done_valid) begin
        got_t.push_back(cyc); got_a.push_back(done_addr); got_m.push_back(done_mem);
      end
    end
  end

  function automatic int find_t(logic [31:0] a);
    foreach (got_a[i]) if (got_a[i] == a) return got_t[i];
    return -1;
  endfunction

  function automatic int find_m(logic [31:0] a);
    foreach (got_a[i]) if (got_a[i] == a) return int'(got_m[i]);
    return -1;
  endfunction

  task automatic drive(bit mv, logic [31:0] ma, bit fv, logic [31:0] fa, output int t0);
    @(negedge clk);
    mreq_valid = mv; mreq_addr = ma; freq_valid = fv; freq_addr = fa;
    t0 = cyc;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    mreq_valid = 1'b0; freq_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int ta, tb, tc, td, te, tf, tbk, tmp;
    int dropped[$];
    logic [31:0] lcg;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done_valid after reset", 64'(done_valid), 64'd0);
    chk("R1 q_full after reset", 64'(q_full), 64'd0);

    // closed bank, issued the cycle it arrives
    drive(1, 32'h0000_0000, 0, 0, ta); idle(400);
    chk("R1 R3 R6 closed-bank latency", 64'(find_t(32'h0000_0000) - ta), 64'd249);
    // same row, other column bits: hit
    drive(1, 32'h0000_0100, 0, 0, tb); idle(300);
    chk("R2 R3 row-hit latency", 64'(find_t(32'h0000_0100) - tb), 64'd149);
    // other row in same bank: miss, fetch source
    drive(0, 0, 1, 32'h0001_0000, tc); idle(500);
    chk("R3 row-miss latency", 64'(find_t(32'h0001_0000) - tc), 64'd349);
    chk("R9 fetch source flag", 64'(find_m(32'h0001_0000)), 64'd0);
    // both ports together, different closed banks: data bus pushes second
    drive(1, 32'h0002_0020, 1, 32'h0002_0040, td); idle(500);
    chk("R8 memory-stage first", 64'(find_t(32'h0002_0020) - td), 64'd249);
    chk("R4 data-bus spacing", 64'(find_t(32'h0002_0040) - td), 64'd299);
    chk("R9 memory source flag", 64'(find_m(32'h0002_0020)), 64'd1);
    // bank busy: hit to bank 3 waits for bank release
    drive(1, 32'h0000_0060, 0, 0, te); drive(1, 32'h0000_0160, 0, 0, tmp); idle(500);
    chk("R5 closed first", 64'(find_t(32'h0000_0060) - te), 64'd249);
    chk("R5 bank busy wait", 64'(find_t(32'h0000_0160) - te), 64'd349);
    // open bank4 row5 and bank5 row7
    drive(1, 32'h0005_0080, 1, 32'h0007_00A0, tf); idle(600);
    // blocker miss on bank5, older closed fetch, newer hit on bank4
    drive(1, 32'h0000_00A0, 0, 0, tbk);
    drive(0, 0, 1, 32'h0000_00C0, tmp);
    drive(1, 32'h0005_0180, 0, 0, tmp);
    idle(600);
    chk("R4 blocker miss", 64'(find_t(32'h0000_00A0) - tbk), 64'd349);
    chk("R7 row hit beats older", 64'(find_t(32'h0005_0180) - tbk), 64'd153);
    chk("R7 R8 older after hit", 64'(find_t(32'h0000_00C0) - tbk), 64'd257);

    // fill the queue with bank-7 misses on both ports
    for (int i = 0; i < 10; i++) begin
      drive(1, {16'(2*i + 1), 16'h00E0}, 1, {16'(2*i + 2), 16'h00E0}, tmp);
      if (q_full) begin
        dropped.push_back(2*i + 1);
        dropped.push_back(2*i + 2);
      end
    end
    idle(7000);
    chk("R10 queue reached full", 64'(dropped.size() > 0), 64'd1);
    foreach (dropped[i])
      chk("R10 dropped request never completes",
          64'(find_t({16'(dropped[i]), 16'h00E0}) >= 0), 64'd0);

    // mixed traffic checked cycle by cycle against the model
    lcg = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] am, af;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      am = {14'd0, lcg[31:30], 8'h00, lcg[29:27], 5'd0};
      af = {14'd0, lcg[26:25], 8'h01, lcg[24:22], 5'd0};
      drive(lcg[21:19] == 3'd0, am, lcg[18:16] == 3'd1, af, tmp);
    end
    idle(9000);
    chk("R6 model queue drained", 64'(mq.size()), 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule